// File: doc/BRIEF.md
# Mode-Selectable Register GPIO

This block controls a group of general-purpose pins through a small synchronous register bus. Each pin has a two-bit drive mode. The mode picks one of four behaviours: push-pull output, input only, drive-low-only (open-drain) or drive-high-only (open-source). From the mode and the stored output bit, the block produces a registered output value and a registered output enable for each pad.

Pad inputs pass through a two-stage synchronizer. The synchronized value is captured into an input register only for pins whose digital input enable bit is set. A pin whose enable is clear keeps its last captured value. That pin can then serve an analog function without a floating digital receiver.

Software can rewrite the whole output latch in one write. It can also set, clear or invert chosen bits through three write-only strobe addresses, which read back as zero.

Top module: `mgpio_top`

## Requirements
- R1: After reset, the output latch, the mode register, the input-enable register and the input register are all zero. Every pin then drives 0 with its output enable at 1.
- R2: Address map (byte offsets): 0x00 output latch (read/write), 0x04 mode (read/write), 0x08 input register (read-only), 0x0C set strobe, 0x10 clear strobe, 0x14 invert strobe, 0x18 input enable (read/write).
- R3: Pin n's mode sits in mode bits [2n+1:2n] with the encoding 00 push-pull, 01 input, 10 open-drain, 11 open-source. In push-pull mode the pad value equals the latch bit and the output enable is 1.
- R4: In input mode the output enable is 0, whatever the latch bit is.
- R5: In open-drain mode, latch bit 0 gives value 0 with enable 1. Latch bit 1 gives enable 0.
- R6: In open-source mode, latch bit 1 gives value 1 with enable 1. Latch bit 0 gives enable 0.
- R7: For each 1 bit in write data, a write to the set, clear or invert strobe sets, clears or inverts the matching latch bit. Latch bits under a 0 bit are unchanged.
- R8: The set, clear and invert strobe addresses always read as 0.
- R9: Input register bit n takes the pad value two synchronizer cycles later, plus one capture cycle, while enable bit n is 1. While enable bit n is 0 it holds its value.
- R10: Reads of unmapped offsets return 0. Data bits above the register width read as 0 and are ignored on write. Pad outputs and read data update one cycle after the causing write or read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| pad_in | input | 8 | Asynchronous pad input values |
| pad_out | output | 8 | Registered pad drive value |
| pad_oe | output | 8 | Registered pad output enable |

## Verification
The bench writes random latch and mode values and checks every pin's value and enable against a model of the four modes. A design that swaps the drive-low-only and drive-high-only codes would drive the wrong level, or release the wrong level. The bench mixes strobe writes with patterns that have both 0 and 1 bits. A strobe that writes the whole data word, instead of acting per bit, would clobber latch bits that should not change. The bench also changes the pad inputs while their enables are clear. An input register that keeps sampling would show the new pad value instead of the held one. Reads of the strobe addresses and of unmapped addresses must return zero; a design that returns the latch there would be caught.

// File: rtl/mgpio_pkg.sv
package mgpio_pkg;
  typedef enum logic [1:0] {
    DRV_PUSHPULL = 2'b00,
    DRV_INPUT    = 2'b01,
    DRV_LOWONLY  = 2'b10,
    DRV_HIGHONLY = 2'b11
  } drv_mode_e;

  localparam logic [7:0] OFS_LATCH = 8'h00;
  localparam logic [7:0] OFS_MODE  = 8'h04;
  localparam logic [7:0] OFS_INREG = 8'h08;
  localparam logic [7:0] OFS_SET   = 8'h0C;
  localparam logic [7:0] OFS_CLR   = 8'h10;
  localparam logic [7:0] OFS_INV   = 8'h14;
  localparam logic [7:0] OFS_INEN  = 8'h18;
endpackage

// File: rtl/mgpio_regs.sv
module mgpio_regs
  import mgpio_pkg::*;
#(
  parameter int PINS = 8,
  parameter int AW   = 8,
  parameter int DW   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     addr,
  input  logic              wr,
  input  logic [DW-1:0]     wdata,
  input  logic              rd,
  input  logic [PINS-1:0]   in_q,
  output logic [DW-1:0]     rdata,
  output logic [PINS-1:0]   latch,
  output logic [2*PINS-1:0] mode,
  output logic [PINS-1:0]   inen
);
  localparam int MW = 2 * PINS;

  logic [PINS-1:0] wbits;
  assign wbits = wdata[PINS-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      latch <= '0;
      mode  <= '0;
      inen  <= '0;
    end else if (wr) begin
      case (addr)
        AW'(OFS_LATCH): latch <= wbits;
        AW'(OFS_MODE):  mode  <= wdata[MW-1:0];
        AW'(OFS_SET):   latch <= latch | wbits;
        AW'(OFS_CLR):   latch <= latch & ~wbits;
        AW'(OFS_INV):   latch <= latch ^ wbits;
        AW'(OFS_INEN):  inen  <= wbits;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd) begin
      case (addr)
        AW'(OFS_LATCH): rdata <= DW'(latch);
        AW'(OFS_MODE):  rdata <= DW'(mode);
        AW'(OFS_INREG): rdata <= DW'(in_q);
        AW'(OFS_INEN):  rdata <= DW'(inen);
        default:        rdata <= '0;
      endcase
    end
  end

  AST_STROBE_NOT_LATCH: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == AW'(OFS_SET)) |=> ((latch & $past(wbits)) == $past(wbits))); // R7
  AST_CLR_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == AW'(OFS_CLR)) |=> ((latch & ~$past(wbits)) == ($past(latch) & ~$past(wbits)))); // R7
  AST_STROBE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd && (addr == AW'(OFS_SET) || addr == AW'(OFS_CLR) || addr == AW'(OFS_INV))) |=> (rdata == '0)); // R8
endmodule

// File: rtl/mgpio_insamp.sv
module mgpio_insamp #(
  parameter int PINS   = 8,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] pad_in,
  input  logic [PINS-1:0] inen,
  output logic [PINS-1:0] in_q
);
  logic [PINS-1:0] sync [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) sync[s] <= '0;
    end else begin
      sync[0] <= pad_in;
      for (int s = 1; s < STAGES; s++) sync[s] <= sync[s-1];
    end
  end

  for (genvar p = 0; p < PINS; p++) begin : g_cap
    always_ff @(posedge clk) begin
      if (rst) in_q[p] <= 1'b0;
      else if (inen[p]) in_q[p] <= sync[STAGES-1][p];
    end
  end

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(inen[0])) |-> $stable(in_q[0])); // R9
endmodule

// File: rtl/mgpio_drive.sv
module mgpio_drive
  import mgpio_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PINS-1:0]   latch,
  input  logic [2*PINS-1:0] mode,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe
);
  for (genvar p = 0; p < PINS; p++) begin : g_pin
    drv_mode_e m;
    logic v, e;
    assign m = drv_mode_e'(mode[2*p +: 2]);
    always_comb begin
      unique case (m)
        DRV_PUSHPULL: begin v = latch[p]; e = 1'b1;      end
        DRV_INPUT:    begin v = 1'b0;     e = 1'b0;      end
        DRV_LOWONLY:  begin v = 1'b0;     e = ~latch[p]; end
        default:      begin v = 1'b1;     e = latch[p];  end
      endcase
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        pad_out[p] <= 1'b0;
        pad_oe[p]  <= 1'b1;
      end else begin
        pad_out[p] <= v;
        pad_oe[p]  <= e;
      end
    end
  end

  AST_INPUT_NOT_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    (mode[1:0] == 2'b01) |=> !pad_oe[0]); // R4
  AST_LOWONLY_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (mode[1:0] == 2'b10) |=> (!pad_oe[0] || !pad_out[0])); // R5
  AST_HIGHONLY_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (mode[1:0] == 2'b11) |=> (!pad_oe[0] || pad_out[0])); // R6
endmodule

// File: rtl/mgpio_top.sv
module mgpio_top #(
  parameter int PINS   = 8,
  parameter int AW     = 8,
  parameter int DW     = 32,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic [DW-1:0]   bus_wdata,
  input  logic            bus_rd,
  output logic [DW-1:0]   bus_rdata,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_oe
);
  logic [PINS-1:0]   latch, inen, in_q;
  logic [2*PINS-1:0] mode;

  mgpio_regs #(.PINS(PINS), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .rd(bus_rd), .in_q(in_q), .rdata(bus_rdata),
    .latch(latch), .mode(mode), .inen(inen)
  );

  mgpio_insamp #(.PINS(PINS), .STAGES(STAGES)) u_in (
    .clk(clk), .rst(rst), .pad_in(pad_in), .inen(inen), .in_q(in_q)
  );

  mgpio_drive #(.PINS(PINS)) u_drv (
    .clk(clk), .rst(rst), .latch(latch), .mode(mode),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  AST_PUSHPULL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (mode[1:0] == 2'b00) |=> (pad_oe[0] && pad_out[0] == $past(latch[0]))); // R3
endmodule

// File: tb/tb_mgpio_top.sv
module tb_mgpio_top;
  logic clk = 0, rst = 1;
  logic [7:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [7:0] pad_in = 0, pad_out, pad_oe;
  int nchk = 0, nbad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mgpio_top dut (.*);

  logic [7:0]  m_latch = 0, m_inen = 0, m_in = 0;
  logic [15:0] m_mode = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  function automatic logic [15:0] exp_pads(logic [7:0] l, logic [15:0] m);
    logic [7:0] v, e;
    for (int p = 0; p < 8; p++) begin
      case (m[2*p +: 2])
        2'b00: begin v[p] = l[p]; e[p] = 1; end
        2'b01: begin v[p] = 0; e[p] = 0; end
        2'b10: begin v[p] = 0; e[p] = ~l[p]; end
        default: begin v[p] = 1; e[p] = l[p]; end
      endcase
    end
    return {e, v};
  endfunction

  task automatic chk_pads(string req);
    logic [15:0] x;
    @(negedge clk);
    x = exp_pads(m_latch, m_mode);
    chk({req, " oe"}, pad_oe, x[15:8]);
    chk({req, " out&oe"}, pad_out & pad_oe, x[7:0] & x[15:8]);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 out", pad_out, 0); chk("R1 oe", pad_oe, 8'hFF);
    rd(8'h00, d); chk("R1 latch", d, 0);
    rd(8'h04, d); chk("R1 mode", d, 0);
    rd(8'h08, d); chk("R1 inreg", d, 0);
    rd(8'h18, d); chk("R1 inen", d, 0);
    // R2 / R10 map and width masking
    wr(8'h00, 32'hFFFF_FF5A); m_latch = 8'h5A;
    rd(8'h00, d); chk("R2 R10 latch", d, 32'h5A);
    wr(8'h04, 32'hFFFF_1B6C); m_mode = 16'h1B6C;
    rd(8'h04, d); chk("R2 R10 mode", d, 32'h1B6C);
    rd(8'h40, d); chk("R10 unmapped", d, 0);
    // R8
    rd(8'h0C, d); chk("R8 set", d, 0);
    rd(8'h10, d); chk("R8 clr", d, 0);
    rd(8'h14, d); chk("R8 inv", d, 0);
    // R3 directed: all push-pull
    wr(8'h04, 0); m_mode = 0; chk_pads("R3");
    // R4 all input
    wr(8'h04, 32'h5555); m_mode = 16'h5555; chk_pads("R4");
    // R5/R6
    wr(8'h04, 32'hAAAA); m_mode = 16'hAAAA; chk_pads("R5");
    wr(8'h04, 32'hFFFF); m_mode = 16'hFFFF; chk_pads("R6");
    // random mixes
    for (int i = 0; i < 200; i++) begin
      int op = $urandom_range(0, 4);
      logic [31:0] r = $urandom;
      case (op)
        0: begin wr(8'h00, r); m_latch = r[7:0]; end
        1: begin wr(8'h04, r); m_mode = r[15:0]; end
        2: begin wr(8'h0C, r); m_latch |= r[7:0]; end
        3: begin wr(8'h10, r); m_latch &= ~r[7:0]; end
        default: begin wr(8'h14, r); m_latch ^= r[7:0]; end
      endcase
      rd(8'h00, d); chk("R7 latch", d, {24'h0, m_latch});
      chk_pads("R3 R4 R5 R6 mix");
    end
    // R9 input capture
    wr(8'h18, 32'h0F); m_inen = 8'h0F;
    for (int i = 0; i < 20; i++) begin
      logic [7:0] pv = 8'($urandom);
      @(negedge clk); pad_in = pv;
      repeat (4) @(negedge clk);
      m_in = (m_in & ~m_inen) | (pv & m_inen);
      rd(8'h08, d); chk("R9 inreg", d, {24'h0, m_in});
      if (i == 10) begin wr(8'h18, 32'hF0); m_inen = 8'hF0; end
    end
    wr(8'h18, 0); m_inen = 0;
    @(negedge clk); pad_in = ~pad_in;
    repeat (5) @(negedge clk);
    rd(8'h08, d); chk("R9 hold", d, {24'h0, m_in});
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule